// File: doc/BRIEF.md
# Driver Impedance Calibration Sequencer

This block finds the pull-up and pull-down strength codes for a memory output driver. It presents trial codes to an external analog comparator, powers the comparator for a settle window of at least 300 ns and reads back one result bit. It first steps a 5-bit pull-up code upward and compares it against the external precision resistor. It then steps a 4-bit pull-down code upward and compares it against the pull-up code it just found. Each trial code goes out together with its +1 neighbour code.

When both searches are complete, the block commits the codes to the driver buffers. Two load paths exist. One raises a trigger while an enable is held, so the buffers see a rising edge. The other asserts a select and an enable together for one cycle. A calibration starts on a one-cycle request. It also starts by itself after a fixed number of idle cycles, which defaults to 5 minutes at 200 MHz.

Top module: `imp_cal_seq`

## Requirements
- R1: Pull-up search. The search drives pull-up codes 0, 1, 2 and upward with `cmp_mode_o`=0 and `pd_code_o`=0. The chosen pull-up code is the first code for which `cmp_i` reads 1.
- R2: If `cmp_i` reads 0 for every pull-up code up to and including 31, the chosen pull-up code is 0.
- R3: Pull-down search. The search holds `pu_code_o` at the chosen pull-up code and sets `cmp_mode_o`=1. It drives pull-down codes 0 to 14 in rising order and never drives 15. The first trial above 0 that reads 0 selects that trial code minus one.
- R4: If no trial from 1 to 14 reads 0, the chosen pull-down code is 0.
- R5: For each trial, the codes are set while `cmp_en_o` is low for one cycle. `cmp_en_o` is then high for SETTLE_CYC consecutive cycles, during which the codes stay stable. The result is sampled at the end of the last enabled cycle. SETTLE_CYC = ceil(SETTLE_NS*1000/CLK_PS), which is 60 by default. `cmp_en_o` is low whenever no trial is running.
- R6: `pu_next_o` equals `pu_code_o`+1, saturating at 31. `pd_next_o` equals `pd_code_o`+1, saturating at 15.
- R7: Hardware load (`load_path_i`=0 when the calibration starts). `ld_en_o` is high for three cycles, while `ld_trig_o` is low, then high, then low. `ld_sel_o` stays 0.
- R8: Software load (`load_path_i`=1 when the calibration starts). `ld_sel_o` and `ld_en_o` are high together for one cycle and are both low in the next cycle.
- R9: `pu_fin_o` and `pd_fin_o` change only at commit. `done_o` is high for exactly one cycle, which is the first cycle in which the new final codes are visible. The final codes are 0 after reset.
- R10: `busy_o` rises in the cycle after `start_i` is sampled high in idle. It stays high through the `done_o` cycle and then falls. A `start_i` pulse while busy has no effect.
- R11: After reset, and after each commit, a calibration starts by itself once INTERVAL_CYC idle cycles have passed without a request.
- R12: During reset all strobes, `busy_o`, `done_o` and `cmp_en_o` are 0, and all codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle calibration request |
| load_path_i | input | 1 | Load path, sampled at start: 0 hardware edge load, 1 software load |
| cmp_i | input | 1 | Comparator result |
| cmp_en_o | output | 1 | Comparator power enable |
| cmp_mode_o | output | 1 | 0 pull-up vs resistor, 1 pull-up vs pull-down |
| pu_code_o | output | 5 | Pull-up code presented |
| pu_next_o | output | 5 | Pull-up neighbour code |
| pd_code_o | output | 4 | Pull-down code presented |
| pd_next_o | output | 4 | Pull-down neighbour code |
| ld_en_o | output | 1 | Load enable |
| ld_trig_o | output | 1 | Hardware load trigger |
| ld_sel_o | output | 1 | Software load select |
| pu_fin_o | output | 5 | Committed pull-up code |
| pd_fin_o | output | 4 | Committed pull-down code |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle commit pulse |

## Verification
The embedded assertions check the following on every cycle:
- each enabled window lasts at least the settle count, with codes held steady;
- pull-down code 15 is never compared;
- the neighbour codes never fall below the main codes;
- the final codes move only with the done pulse;
- the ordering of the load strobes is correct.

Some behaviour depends on the comparator's answer sequence, so only the bench scenarios can show it. This covers the first-one and last-one selection, the fallback to 0 when no transition appears, a request ignored mid-run, and the exact idle spacing of the periodic rerun.

// File: rtl/imp_cal_seq.sv
module imp_cal_seq #(
  parameter int              CLK_PS       = 5000,
  parameter int              SETTLE_NS    = 300,
  parameter longint unsigned INTERVAL_CYC = 64'd60_000_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       load_path_i,
  input  logic       cmp_i,
  output logic       cmp_en_o,
  output logic       cmp_mode_o,
  output logic [4:0] pu_code_o,
  output logic [4:0] pu_next_o,
  output logic [3:0] pd_code_o,
  output logic [3:0] pd_next_o,
  output logic       ld_en_o,
  output logic       ld_trig_o,
  output logic       ld_sel_o,
  output logic [4:0] pu_fin_o,
  output logic [3:0] pd_fin_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int SETTLE_CYC = (SETTLE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int TW = $clog2(INTERVAL_CYC + 1);
  localparam logic [TW-1:0] TMAX = TW'(INTERVAL_CYC - 1);
  localparam logic [SW-1:0] SLAST = SW'(SETTLE_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PU_GAP, S_PU_CMP, S_PD_GAP, S_PD_CMP, S_LD_ARM, S_LD_FIRE, S_LD_CLR
  } st_t;

  st_t           st;
  logic [4:0]    idx;
  logic [SW-1:0] scnt;
  logic [TW-1:0] tcnt;
  logic [4:0]    pu_sel;
  logic [3:0]    pd_sel;
  logic          sw_q;

  wire in_pu = (st == S_PU_GAP) || (st == S_PU_CMP);
  wire in_pd = (st == S_PD_GAP) || (st == S_PD_CMP);
  wire last  = (scnt == SLAST);

  assign cmp_en_o   = (st == S_PU_CMP) || (st == S_PD_CMP);
  assign cmp_mode_o = in_pd;
  assign pu_code_o  = in_pu ? idx : pu_sel;
  assign pd_code_o  = in_pd ? idx[3:0] : (in_pu ? 4'd0 : pd_sel);
  assign pu_next_o  = (pu_code_o == 5'd31) ? 5'd31 : pu_code_o + 5'd1;
  assign pd_next_o  = (pd_code_o == 4'd15) ? 4'd15 : pd_code_o + 4'd1;
  assign ld_en_o    = (st == S_LD_ARM) || (st == S_LD_FIRE) || ((st == S_LD_CLR) && !sw_q);
  assign ld_trig_o  = (st == S_LD_FIRE) && !sw_q;
  assign ld_sel_o   = (st == S_LD_FIRE) && sw_q;
  assign busy_o     = (st != S_IDLE);
  assign done_o     = (st == S_LD_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; scnt <= '0; tcnt <= '0;
      pu_sel <= '0; pd_sel <= '0; sw_q <= 1'b0;
      pu_fin <= '0; pd_fin <= '0;
    end else begin
      unique case (st)
        S_IDLE:
          if (start_i || tcnt == TMAX) begin
            st <= S_PU_GAP; idx <= '0; tcnt <= '0; sw_q <= load_path_i;
          end else tcnt <= tcnt + 1'b1;
        S_PU_GAP: begin st <= S_PU_CMP; scnt <= '0; end
        S_PU_CMP: begin
          scnt <= scnt + 1'b1;
          if (last) begin
            if (cmp_i) begin pu_sel <= idx; idx <= '0; st <= S_PD_GAP; end
            else if (idx == 5'd31) begin pu_sel <= '0; idx <= '0; st <= S_PD_GAP; end
            else begin idx <= idx + 5'd1; st <= S_PU_GAP; end
          end
        end
        S_PD_GAP: begin st <= S_PD_CMP; scnt <= '0; end
        S_PD_CMP: begin
          scnt <= scnt + 1'b1;
          if (last) begin
            if (!cmp_i && idx != 5'd0) begin
              pd_sel <= idx[3:0] - 4'd1; st <= sw_q ? S_LD_FIRE : S_LD_ARM;
            end else if (idx == 5'd14) begin
              pd_sel <= '0; st <= sw_q ? S_LD_FIRE : S_LD_ARM;
            end else begin idx <= idx + 5'd1; st <= S_PD_GAP; end
          end
        end
        S_LD_ARM:  st <= S_LD_FIRE;
        S_LD_FIRE: begin pu_fin <= pu_sel; pd_fin <= pd_sel; st <= S_LD_CLR; end
        S_LD_CLR:  begin st <= S_IDLE; tcnt <= '0; end
        default:   st <= S_IDLE;
      endcase
    end
  end

  logic [4:0] pu_fin;
  logic [3:0] pd_fin;
  assign pu_fin_o = pu_fin;
  assign pd_fin_o = pd_fin;

  logic [SW:0] chk_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chk_run <= '0;
    else chk_run <= cmp_en_o ? chk_run + 1'b1 : '0;

  assert_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmp_en_o) |-> chk_run >= (SW+1)'(SETTLE_CYC));
  assert_codes_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en_o && $past(cmp_en_o)) |-> ($stable(pu_code_o) && $stable(pd_code_o)));
  assert_pu_pd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en_o && !cmp_mode_o) |-> pd_code_o == 4'd0);
  assert_pd_no_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en_o && cmp_mode_o) |-> pd_code_o != 4'd15);
  assert_next_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_next_o >= pu_code_o) && (pd_next_o >= pd_code_o));
  assert_trig_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_trig_o) |-> ($past(ld_en_o) && ld_en_o && !ld_sel_o));
  assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_sel_o) |-> (!ld_en_o && !ld_trig_o));
  assert_fin_only_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_fin_o != $past(pu_fin_o)) || (pd_fin_o != $past(pd_fin_o))) |-> done_o);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));
endmodule

// File: tb/imp_cal_seq_tb_top.sv
module imp_cal_seq_tb_top;
  localparam int SETTLE = 60;
  localparam int INTERVAL = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic load_path_i = 1'b0;
  logic cmp_i;
  logic cmp_en_o, cmp_mode_o, ld_en_o, ld_trig_o, ld_sel_o, busy_o, done_o;
  logic [4:0] pu_code_o, pu_next_o, pu_fin_o;
  logic [3:0] pd_code_o, pd_next_o, pd_fin_o;

  int tests = 0, fails = 0, cyc = 0;
  int pu_th = 32, pd_th = 14;
  bit model_on = 0;

  int e_pu = 0, e_pd = 0, e_pufin = 0, e_pdfin = 0;
  bit e_en = 0, e_mode = 0, e_len = 0, e_trig = 0, e_sel = 0, e_busy = 0, e_done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  imp_cal_seq #(.CLK_PS(5000), .SETTLE_NS(300), .INTERVAL_CYC(INTERVAL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_path_i(load_path_i), .cmp_i(cmp_i),
    .cmp_en_o(cmp_en_o), .cmp_mode_o(cmp_mode_o), .pu_code_o(pu_code_o), .pu_next_o(pu_next_o),
    .pd_code_o(pd_code_o), .pd_next_o(pd_next_o), .ld_en_o(ld_en_o), .ld_trig_o(ld_trig_o),
    .ld_sel_o(ld_sel_o), .pu_fin_o(pu_fin_o), .pd_fin_o(pd_fin_o), .busy_o(busy_o), .done_o(done_o));

  function automatic bit ref_cmp(int pu, int pd, bit mode);
    return mode ? (pd <= pd_th) : (pu >= pu_th);
  endfunction

  assign cmp_i = cmp_en_o ? ref_cmp(int'(pu_code_o), int'(pd_code_o), cmp_mode_o) : 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic run_cal();
    bit sw = load_path_i;
    int pu_r = 0, pd_r = 0;
    bit found = 0;
    e_busy = 1;
    for (int i = 0; i < 32 && !found; i++) begin
      e_mode = 0; e_pu = i; e_pd = 0; e_en = 0;
      @(posedge clk); e_en = 1;
      repeat (SETTLE) @(posedge clk);
      if (ref_cmp(i, 0, 0)) begin pu_r = i; found = 1; end
    end
    found = 0;
    for (int i = 0; i < 15 && !found; i++) begin
      e_mode = 1; e_pu = pu_r; e_pd = i; e_en = 0;
      @(posedge clk); e_en = 1;
      repeat (SETTLE) @(posedge clk);
      if (!ref_cmp(pu_r, i, 1) && i > 0) begin pd_r = i - 1; found = 1; end
    end
    e_en = 0; e_mode = 0; e_pu = pu_r; e_pd = pd_r;
    if (!sw) begin
      e_len = 1; @(posedge clk);
      e_trig = 1; @(posedge clk);
      e_trig = 0; e_done = 1; e_pufin = pu_r; e_pdfin = pd_r; @(posedge clk);
    end else begin
      e_len = 1; e_sel = 1; @(posedge clk);
      e_len = 0; e_sel = 0; e_done = 1; e_pufin = pu_r; e_pdfin = pd_r; @(posedge clk);
    end
    e_len = 0; e_done = 0; e_busy = 0;
  endtask

  initial begin : model
    int tc = 0;
    @(posedge rst_n);
    model_on = 1;
    forever begin
      @(posedge clk);
      if (start_i || tc == INTERVAL - 1) begin tc = 0; run_cal(); end
      else tc++;
    end
  end

  always @(negedge clk) if (rst_n && model_on) begin
    chk(busy_o == e_busy, "R10 busy", busy_o, e_busy);
    chk(cmp_en_o == e_en, "R5 cmp_en", cmp_en_o, e_en);
    chk(cmp_mode_o == e_mode, "R3 mode", cmp_mode_o, e_mode);
    chk(int'(pu_code_o) == e_pu, "R1 pu_code", pu_code_o, e_pu);
    chk(int'(pd_code_o) == e_pd, "R3 pd_code", pd_code_o, e_pd);
    chk(int'(pu_next_o) == (e_pu == 31 ? 31 : e_pu + 1), "R6 pu_next", pu_next_o, e_pu == 31 ? 31 : e_pu + 1);
    chk(int'(pd_next_o) == (e_pd == 15 ? 15 : e_pd + 1), "R6 pd_next", pd_next_o, e_pd == 15 ? 15 : e_pd + 1);
    chk(ld_en_o == e_len, "R7/R8 ld_en", ld_en_o, e_len);
    chk(ld_trig_o == e_trig, "R7 ld_trig", ld_trig_o, e_trig);
    chk(ld_sel_o == e_sel, "R8 ld_sel", ld_sel_o, e_sel);
    chk(done_o == e_done, "R9 done", done_o, e_done);
    chk(int'(pu_fin_o) == e_pufin, "R9 pu_fin", pu_fin_o, e_pufin);
    chk(int'(pd_fin_o) == e_pdfin, "R9 pd_fin", pd_fin_o, e_pdfin);
  end

  function automatic int exp_pu(int th);
    return (th <= 31) ? th : 0;
  endfunction
  function automatic int exp_pd(int th);
    if (th < 0) return 0;
    if (th <= 13) return th;
    return 0;
  endfunction

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  task automatic do_cal(int put, int pdt, bit path, string tag);
    @(negedge clk);
    pu_th = put; pd_th = pdt; load_path_i = path; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
    repeat (100) @(negedge clk);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    wait_done();
    chk(int'(pu_fin_o) == exp_pu(put), {tag, " final pu"}, pu_fin_o, exp_pu(put));
    chk(int'(pd_fin_o) == exp_pd(pdt), {tag, " final pd"}, pd_fin_o, exp_pd(pdt));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R10 actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    int c0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && cmp_en_o == 0 && done_o == 0, "R12 reset strobes", busy_o | cmp_en_o | done_o, 0);
    chk(ld_en_o == 0 && ld_trig_o == 0 && ld_sel_o == 0, "R12 reset load", ld_en_o | ld_trig_o | ld_sel_o, 0);
    chk(pu_fin_o == 0 && pd_fin_o == 0 && pu_code_o == 0 && pd_code_o == 0, "R12 reset codes",
        int'(pu_fin_o) + int'(pd_fin_o) + int'(pu_code_o) + int'(pd_code_o), 0);
    rst_n = 1;
    do_cal(9, 5, 1'b0, "R1 R3 R7");
    do_cal(0, 14, 1'b0, "R1 R4");
    do_cal(32, 0, 1'b1, "R2 R8");
    do_cal(31, -1, 1'b1, "R3 R4");
    do_cal(17, 13, 1'b0, "R3");
    c0 = cyc;
    @(negedge clk);
    pu_th = 4; pd_th = 2; load_path_i = 1;
    while (!busy_o) @(negedge clk);
    chk(cyc == c0 + 1 + INTERVAL, "R11 periodic start cycle", cyc, c0 + 1 + INTERVAL);
    wait_done();
    chk(int'(pu_fin_o) == 4 && int'(pd_fin_o) == 2, "R11 periodic result",
        int'(pu_fin_o) * 16 + int'(pd_fin_o), 4 * 16 + 2);
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule